// File: doc/BRIEF.md
# Shadowed Multi-Channel Clock-Enable Divider

The block turns one fast input clock into nine clock-enable pulse trains. Each channel has its own divide ratio, taken from a 4-bit code that selects one of a set of ratios including odd and non-power-of-two values. Software programs the codes through two 32-bit registers on a simple single-cycle register bus. Writes land in shadow storage and do not touch the running channels.

Software then sets a commit request bit. The block holds that bit high for a fixed number of cycles and then copies every shadow code into the live dividers on a single edge, restarting all channel counters together. Codes that a channel does not accept are dropped field by field and raise a sticky error. Writes that arrive while a commit is outstanding are refused and flagged. One channel can be switched to a 1:1 pass-through. A fixed divide-by-4 tap follows that channel.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: Code to ratio: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48, 12→7; codes 9 and 13..15 are never accepted. A channel with ratio R raises its enable for one cycle in every R cycles.
- R2: Register select 0 holds channel 0 at bits 23:20, channel 1 at 19:16, channel 2 at 15:12, channel 3 at 11:8, channel 4 at 7:4 and channel 5 at 3:0. Register select 1 holds channel 6 at 27:24, channel 7 at 15:12 and channel 8 at 7:4. Reads return the shadow codes.
- R3: Accepted codes per channel, given as a 13-bit mask with bit n for code n: channels 0, 3, 7, 8 use 0xDFF, channels 2, 4, 5 use 0x1DFF, channel 1 uses 0xD7F, channel 6 uses 0x97F. A refused field keeps its previous shadow code. Other fields in the same write are still stored.
- R4: Any refused field sets err_o, which stays set until reset.
- R5: Writing 1 to bit 31 of register 1 starts a commit. Bit 31 reads 1 for exactly KICK_CYCLES cycles after the write edge. It then reads 0, and every shadow value becomes live on that same edge.
- R6: A write while bit 31 reads 1 is refused entirely, including a write on the commit edge itself. busy_o is high in the cycle after such a write and low otherwise.
- R7: Shadow writes do not change any channel output until a commit.
- R8: On the commit edge every channel counter restarts. A channel with ratio R gives its first enable R-1 cycles after the first cycle in which bit 31 reads 0.
- R9: Bit 28 of register 1 is the channel-6 divider enable. It is shadowed and committed like the codes. When 0, ce_o[6] is high every cycle. When 1, channel 6 uses its code.
- R10: zq_ce_o pulses on every fourth enable of channel 6, and only together with ce_o[6].
- R11: After reset all codes are 0 (ratio 2), the channel-6 divider enable is 1, bit 31 is 0, err_o and busy_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write qualifier for req_i |
| sel_i | input | 1 | Register select (0 or 1) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| busy_o | output | 1 | A write was refused during a commit |
| err_o | output | 1 | Sticky refused-code flag |
| ce_o | output | 9 | Per-channel clock-enable pulses |
| zq_ce_o | output | 1 | Channel 6 enable divided by 4 |

## Verification
A bus write and the commit can fall on the same edge: the last cycle of an outstanding commit is also the edge where the live codes are loaded. The bench provokes this by issuing a write timed so that it is latched exactly on that edge. It judges the result by busy_o in the following cycle and by reading back that the field kept its old shadow code. It then checks that a write one cycle later is accepted and reads back.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int NCH      = 9;
  localparam int CODE_W   = 4;
  localparam int RATIO_W  = 6;
  localparam int Z_CH     = 6;
  localparam int ZEN_BIT  = 28;
  localparam int KICK_BIT = 31;

  localparam int           FIELD_LSB  [NCH] = '{20, 16, 12, 8, 4, 0, 24, 12, 4};
  localparam logic         FIELD_SEL  [NCH] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                                1'b1, 1'b1, 1'b1};
  localparam logic [15:0]  LEGAL_MASK [NCH] = '{16'h0DFF, 16'h0D7F, 16'h1DFF, 16'h0DFF,
                                                16'h1DFF, 16'h1DFF, 16'h097F, 16'h0DFF,
                                                16'h0DFF};

  function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return 6'd2;
      4'd1:    return 6'd3;
      4'd2:    return 6'd4;
      4'd3:    return 6'd6;
      4'd4:    return 6'd8;
      4'd5:    return 6'd12;
      4'd6:    return 6'd16;
      4'd7:    return 6'd18;
      4'd8:    return 6'd24;
      4'd10:   return 6'd36;
      4'd11:   return 6'd48;
      4'd12:   return 6'd7;
      default: return 6'd2;
    endcase
  endfunction

  function automatic logic code_legal(input int ch, input logic [CODE_W-1:0] code);
    return LEGAL_MASK[ch][code];
  endfunction
endpackage

// File: rtl/ratio_regs.sv
module ratio_regs
  import clk_ratio_pkg::*;
#(
  parameter int KICK_CYCLES = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic                         sel_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output logic                         busy_o,
  output logic                         err_o,
  output logic                         pending_o,
  output logic                         commit_o,
  output logic [NCH-1:0][CODE_W-1:0]   active_o,
  output logic                         zen_o
);
  localparam int KW = (KICK_CYCLES > 1) ? $clog2(KICK_CYCLES) : 1;

  logic [NCH-1:0][CODE_W-1:0] shadow_q, shadow_d, active_q;
  logic                       zen_sh_q, zen_sh_d, zen_act_q;
  logic                       pend_q, busy_q, err_q, err_set, kick_set;
  logic [KW-1:0]              kcnt_q;
  logic [CODE_W-1:0]          fcode;
  logic                       wr, wr_ok, commit;

  assign wr     = req_i & we_i;
  assign wr_ok  = wr & ~pend_q;
  assign commit = pend_q & (kcnt_q == KW'(KICK_CYCLES - 1));

  always_comb begin
    shadow_d = shadow_q;
    zen_sh_d = zen_sh_q;
    err_set  = 1'b0;
    kick_set = 1'b0;
    fcode    = '0;
    if (wr_ok) begin
      for (int c = 0; c < NCH; c++) begin
        if (FIELD_SEL[c] == sel_i) begin
          fcode = wdata_i[FIELD_LSB[c] +: CODE_W];
          if (code_legal(c, fcode)) shadow_d[c] = fcode;
          else                      err_set     = 1'b1;
        end
      end
      if (sel_i) begin
        zen_sh_d = wdata_i[ZEN_BIT];
        kick_set = wdata_i[KICK_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q  <= '0;
      active_q  <= '0;
      zen_sh_q  <= 1'b1;
      zen_act_q <= 1'b1;
      pend_q    <= 1'b0;
      kcnt_q    <= '0;
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      zen_sh_q <= zen_sh_d;
      busy_q   <= wr & pend_q;
      err_q    <= err_q | err_set;
      if (commit) begin
        active_q  <= shadow_q;
        zen_act_q <= zen_sh_q;
        pend_q    <= 1'b0;
        kcnt_q    <= '0;
      end else if (pend_q) begin
        kcnt_q <= kcnt_q + KW'(1);
      end else if (kick_set) begin
        pend_q <= 1'b1;
        kcnt_q <= '0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++)
      if (FIELD_SEL[c] == sel_i) rdata_o[FIELD_LSB[c] +: CODE_W] = shadow_q[c];
    if (sel_i) begin
      rdata_o[ZEN_BIT]  = zen_sh_q;
      rdata_o[KICK_BIT] = pend_q;
    end
  end

  assign busy_o    = busy_q;
  assign err_o     = err_q;
  assign pending_o = pend_q;
  assign commit_o  = commit;
  assign active_o  = active_q;
  assign zen_o     = zen_act_q;
endmodule

// File: rtl/ratio_chan.sv
module ratio_chan
  import clk_ratio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bypass_i,
  input  logic              restart_i,
  output logic              ce_o
);
  logic [RATIO_W-1:0] ratio, cnt_q;
  logic               last;

  assign ratio = code_ratio(code_i);
  assign last  = (cnt_q == ratio - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i|last) cnt_q <= '0;
    else                     cnt_q <= cnt_q + RATIO_W'(1);
  end

  assign ce_o = bypass_i | last;
endmodule

// File: rtl/quarter_tap.sv
module quarter_tap #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_ce_i,
  input  logic restart_i,
  output logic ce_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (src_ce_i && wrap)  cnt_q <= '0;
    else if (src_ce_i)          cnt_q <= cnt_q + W'(1);
  end

  assign ce_o = src_ce_i & wrap;
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int KICK_CYCLES = 8,
  parameter int TAP_DIV     = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic           sel_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  output logic           busy_o,
  output logic           err_o,
  output logic [NCH-1:0] ce_o,
  output logic           zq_ce_o
);
  logic [NCH-1:0][CODE_W-1:0] active;
  logic                       pending, commit, zen;

  ratio_regs #(.KICK_CYCLES(KICK_CYCLES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .sel_i     (sel_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .busy_o    (busy_o),
    .err_o     (err_o),
    .pending_o (pending),
    .commit_o  (commit),
    .active_o  (active),
    .zen_o     (zen)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic byp;
    if (c == Z_CH) begin : g_byp
      assign byp = ~zen;
    end else begin : g_nobyp
      assign byp = 1'b0;
    end
    ratio_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .code_i    (active[c]),
      .bypass_i  (byp),
      .restart_i (commit),
      .ce_o      (ce_o[c])
    );
  end

  quarter_tap #(.DIV(TAP_DIV)) u_tap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_ce_i  (ce_o[Z_CH]),
    .restart_i (commit),
    .ce_o      (zq_ce_o)
  );
endmodule

// File: rtl/clk_ratio_ctrl_chk.sv
module clk_ratio_ctrl_chk
  import clk_ratio_pkg::*;
#(
  parameter int KICK_CYCLES = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic                       pending_i,
  input logic                       commit_i,
  input logic                       busy_i,
  input logic                       err_i,
  input logic                       zen_i,
  input logic [NCH-1:0][CODE_W-1:0] active_i,
  input logic [NCH-1:0]             ce_i,
  input logic                       zq_i
);
  int pcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt <= 0;
    else if (pending_i) pcnt <= pcnt + 1;
    else                pcnt <= 0;
  end

  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);
  a_r5_kick_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_i |-> pcnt < KICK_CYCLES);
  a_r6_busy_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && pending_i) |=> busy_i);
  a_r6_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && pending_i) |=> !busy_i);
  a_r7_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(active_i));
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (ce_i[Z_CH-1:0] == '0) && (ce_i[NCH-1:Z_CH+1] == '0));
  a_r9_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zen_i |-> ce_i[Z_CH]);
  a_r10_tap_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zq_i |-> ce_i[Z_CH]);
endmodule

bind clk_ratio_ctrl clk_ratio_ctrl_chk #(.KICK_CYCLES(KICK_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .pending_i (pending),
  .commit_i  (commit),
  .busy_i    (busy_o),
  .err_i     (err_o),
  .zen_i     (zen),
  .active_i  (active),
  .ce_i      (ce_o),
  .zq_i      (zq_ce_o)
);

// File: tb/sim_clk_ratio_ctrl.sv
`timescale 1ns/1ps
module sim_clk_ratio_ctrl;
  localparam int K = 8;
  // {channel, code, expected period, accepted}
  localparam logic [16:0] VEC [12] = '{
    {4'd2, 4'd12, 8'd7,  1'b1}, {4'd0, 4'd1,  8'd3,  1'b1},
    {4'd0, 4'd12, 8'd3,  1'b0}, {4'd1, 4'd7,  8'd2,  1'b0},
    {4'd1, 4'd8,  8'd24, 1'b1}, {4'd6, 4'd10, 8'd2,  1'b0},
    {4'd6, 4'd11, 8'd48, 1'b1}, {4'd7, 4'd9,  8'd2,  1'b0},
    {4'd8, 4'd5,  8'd12, 1'b1}, {4'd4, 4'd7,  8'd18, 1'b1},
    {4'd5, 4'd15, 8'd2,  1'b0}, {4'd3, 4'd10, 8'd36, 1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic busy, err, zq;
  logic [8:0] ce;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  clk_ratio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .err_o(err),
    .ce_o(ce), .zq_ce_o(zq));

  function automatic int lsb_of(input int ch);
    case (ch)
      0: return 20; 1: return 16; 2: return 12; 3: return 8; 4: return 4;
      5: return 0;  6: return 24; 7: return 12; default: return 4;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; sel = s; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; #1;
  endtask

  task automatic bus_rd(input logic s, output logic [31:0] d);
    sel = s; #1; d = rdata;
  endtask

  task automatic set_field(input int ch, input logic [3:0] code, output logic [3:0] prev);
    logic [31:0] v;
    logic s;
    s = (ch >= 6);
    bus_rd(s, v);
    prev = v[lsb_of(ch) +: 4];
    v[lsb_of(ch) +: 4] = code;
    v[31] = 1'b0;
    bus_wr(s, v);
  endtask

  task automatic kick(output int n);
    logic [31:0] v;
    bus_rd(1'b1, v);
    bus_wr(1'b1, v | 32'h8000_0000);
    n = 0;
    while (rdata[31] && n < 40) begin n++; @(negedge clk); #1; end
  endtask

  function automatic logic sig(input int ch);
    return (ch == 9) ? zq : ce[ch];
  endfunction

  task automatic period(input int ch, output int p);
    int t;
    t = 0;
    while (!sig(ch) && t < 500) begin @(negedge clk); #1; t++; end
    p = 0;
    do begin @(negedge clk); #1; p++; end while (!sig(ch) && p < 500);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [3:0]  prev;
    int p, n;
    int first [9];
    logic err_exp;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    bus_rd(1'b0, v); check("R11 regA reset", v, 0);
    bus_rd(1'b1, v); check("R11 regB reset", v, 32'h1000_0000);
    check("R11 err reset", err, 0);
    check("R11 busy reset", busy, 0);
    period(0, p); check("R11 ch0 ratio", p, 2);
    period(6, p); check("R11 ch6 ratio", p, 2);
    period(9, p); check("R10 tap at reset", p, 8);

    // R1 R2 R3 R4 vector walk
    err_exp = 1'b0;
    for (int i = 0; i < 12; i++) begin
      int ch;
      logic [3:0] code;
      ch = int'(VEC[i][16:13]);
      code = VEC[i][12:9];
      set_field(ch, code, prev);
      err_exp = err_exp | ~VEC[i][0];
      bus_rd(ch >= 6, v);
      check($sformatf("R2/R3 readback vec %0d", i), v[lsb_of(ch) +: 4],
            VEC[i][0] ? code : prev);
      check($sformatf("R4 err vec %0d", i), err, err_exp);
      kick(n);
      period(ch, p);
      check($sformatf("R1 period vec %0d", i), p, VEC[i][8:1]);
    end

    // R7 shadow has no effect before commit
    set_field(3, 4'd2, prev);
    period(3, p); check("R7 ch3 before commit", p, 36);
    bus_rd(1'b0, v); check("R7 ch3 shadow", v[11:8], 2);
    // R8 synchronous restart
    kick(n);
    foreach (first[c]) first[c] = -1;
    for (int idx = 0; idx < 60; idx++) begin
      for (int c = 0; c < 9; c++) if (ce[c] && first[c] < 0) first[c] = idx;
      @(negedge clk); #1;
    end
    check("R8 ch0 first", first[0], 2);
    check("R8 ch2 first", first[2], 6);
    check("R8 ch3 first", first[3], 3);
    check("R8 ch5 first", first[5], 1);
    check("R8 ch8 first", first[8], 11);
    check("R8 ch6 first", first[6], 47);

    // R5 commit latency
    kick(n); check("R5 kick cycles", n, K);
    check("R5 kick clears", rdata[31], 0);

    // R6 write on the commit edge is refused
    bus_rd(1'b1, v);
    bus_wr(1'b1, v | 32'h8000_0000);
    repeat (K - 2) @(negedge clk);
    bus_wr(1'b0, 32'h0000_0003 | (32'h1 << 20) | (32'hC << 12) | (32'hA << 8)
                 | (32'h7 << 4) | (32'h8 << 16));
    check("R6 busy on commit edge", busy, 1);
    bus_rd(1'b1, v); check("R6 kick cleared", v[31], 0);
    bus_rd(1'b0, v); check("R6 ch5 unchanged", v[3:0], 0);
    set_field(5, 4'd3, prev);
    check("R6 busy clear after accept", busy, 0);
    bus_rd(1'b0, v); check("R6 ch5 accepted", v[3:0], 3);

    // R9 R10 bypass and tap
    bus_rd(1'b1, v);
    v[28] = 1'b0;
    bus_wr(1'b1, v);
    period(6, p); check("R9 before commit", p, 48);
    kick(n);
    period(6, p); check("R9 bypass period", p, 1);
    period(9, p); check("R10 tap in bypass", p, 4);
    bus_rd(1'b1, v);
    v[28] = 1'b1;
    bus_wr(1'b1, v);
    kick(n);
    period(6, p); check("R9 divider restored", p, 48);
    period(9, p); check("R10 tap divided", p, 192);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule